// File: doc/BRIEF.md
# Predicated Vector Scatter-Store Sequencer

This block turns one vector scatter-store operation into a series of halfword memory writes. A one-cycle start pulse captures a vector of base addresses, a vector of data, a byte-granular predicate and a 5-bit immediate. The element width for the operation is selected on the same cycle: either 32-bit or 64-bit lanes, over a vector length that is fixed by a parameter. For each active lane, the block forms an address and a 16-bit data word. The address is the lane's base value, zero-extended to 64 bits, plus twice the immediate. The data word is the low half of the lane's data value.

The writes go out on a valid/ready port, lowest lane first. Inactive lanes take no cycles at all. One cycle after the memory side accepts the final write, a single-cycle done pulse is raised. If the predicate selects no lane, the operands are not captured, no write is issued, and done follows the start pulse directly.

Top module: `vscatter_seq`

## Requirements
- R1: While reset is held, and directly after it, `wr_valid_o`, `busy_o` and `done_o` are low.
- R2: With `wide_i` low, the vectors hold VLEN/32 lanes of 32 bits, and lane e occupies bits [32e+31:32e]. With `wide_i` high, they hold VLEN/64 lanes of 64 bits, and lane e occupies bits [64e+63:64e].
- R3: Lane e is active when predicate bit e*4 is set (32-bit lanes) or predicate bit e*8 is set (64-bit lanes). All other predicate bits have no effect.
- R4: The write address for lane e is the zero-extended base lane plus 2*imm, modulo 2^64.
- R5: The write data for lane e is bits [15:0] of the data lane. The upper bits of the lane are dropped.
- R6: An inactive lane produces no write. Exactly one write is accepted per active lane.
- R7: Writes are issued in ascending lane order.
- R8: While `wr_valid_o` is high and `wr_ready_i` is low, the valid, address and data outputs hold. The sequence advances only on an accepted write.
- R9: `done_o` is high for exactly one cycle. That cycle is the one after the final write is accepted, and `busy_o` falls at the same point.
- R10: When no lane is active, no write is issued and `done_o` is high in the cycle after the start pulse.
- R11: A start pulse that arrives while an operation is running is ignored. The writes of the running operation keep their original operands, and later changes to the operand inputs have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that captures an operation |
| wide_i | input | 1 | Lane width: 0 = 32-bit, 1 = 64-bit |
| imm_i | input | 5 | Unsigned immediate, in halfword units |
| base_i | input | VLEN | Vector of base addresses |
| data_i | input | VLEN | Vector of store data |
| pred_i | input | VLEN/8 | Predicate, one bit per data byte |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Memory accepts the write |
| wr_addr_o | output | 64 | Write byte address |
| wr_data_o | output | 16 | Write halfword |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
All 256 lane masks of the 32-bit configuration are applied, and all 16 masks of the 64-bit configuration are applied, so skipping, ordering and the empty-mask exit are each seen for every combination of active lanes. Random values are placed in the non-governing predicate bits. This separates correct predicate decoding from a decoder that reads the wrong bit or ORs a lane's bits together. Base lanes set close to 2^64, paired with every immediate value, show whether the offset is added in halfword units and wraps at 64 bits. Data lanes carry upper halves that differ from their lower halves, so any failure to truncate shows up in the data. Several irregular ready patterns check that outputs hold under stall. A start pulse issued in the middle of an operation, with altered inputs, shows that captured operands are not disturbed.

// File: rtl/vscat_pkg.sv
package vscat_pkg;

   localparam int unsigned ADDR_W = 64;
   localparam int unsigned HALF_W = 16;
   localparam int unsigned IMM_W  = 5;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } seq_state_e;

endpackage

// File: rtl/vscat_pred_decode.sv
module vscat_pred_decode #(
   parameter int unsigned VLEN = 256
)(
   input  logic [VLEN/8-1:0]  pred_i,
   input  logic               wide_i,
   output logic [VLEN/32-1:0] act_o
);
   localparam int unsigned N32 = VLEN / 32;
   localparam int unsigned N64 = VLEN / 64;

   // Each lane is governed by the predicate bit of its lowest byte.
   for (genvar e = 0; e < N32; e++) begin : g_lane
      if (e < N64) begin : g_dual
         assign act_o[e] = wide_i ? pred_i[e*8] : pred_i[e*4];
      end else begin : g_narrow_only
         assign act_o[e] = ~wide_i & pred_i[e*4];
      end
   end

endmodule

// File: rtl/vscat_pick.sv
module vscat_pick #(
   parameter int unsigned N = 8
)(
   input  logic [N-1:0]         pend_i,
   output logic                 any_o,
   output logic [N-1:0]         oh_o,
   output logic [$clog2(N)-1:0] idx_o
);
   localparam int unsigned IDX_W = $clog2(N);

   assign any_o = |pend_i;
   // Isolate the lowest set bit.
   assign oh_o  = pend_i & (~pend_i + N'(1));

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend_i[i]) idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/vscat_lane_sel.sv
module vscat_lane_sel
   import vscat_pkg::*;
#(
   parameter int unsigned VLEN = 256
)(
   input  logic [VLEN-1:0]              base_i,
   input  logic [VLEN-1:0]              data_i,
   input  logic                         wide_i,
   input  logic [$clog2(VLEN/32)-1:0]   idx_i,
   input  logic [IMM_W-1:0]             imm_i,
   output logic [ADDR_W-1:0]            addr_o,
   output logic [HALF_W-1:0]            half_o
);
   localparam int unsigned N32   = VLEN / 32;
   localparam int unsigned N64   = VLEN / 64;
   localparam int unsigned IDX_W = $clog2(N32);

   logic [31:0]       base32, data32;
   logic [63:0]       base64, data64;
   logic [ADDR_W-1:0] base_ext;
   logic [ADDR_W-1:0] offset;

   always_comb begin
      base32 = '0;
      data32 = '0;
      for (int e = 0; e < N32; e++) begin
         if (idx_i == IDX_W'(e)) begin
            base32 = base_i[e*32 +: 32];
            data32 = data_i[e*32 +: 32];
         end
      end
   end

   always_comb begin
      base64 = '0;
      data64 = '0;
      for (int e = 0; e < N64; e++) begin
         if (idx_i == IDX_W'(e)) begin
            base64 = base_i[e*64 +: 64];
            data64 = data_i[e*64 +: 64];
         end
      end
   end

   assign base_ext = wide_i ? base64 : {32'b0, base32};
   assign offset   = ADDR_W'({imm_i, 1'b0});
   assign addr_o   = base_ext + offset;
   assign half_o   = wide_i ? data64[HALF_W-1:0] : data32[HALF_W-1:0];

endmodule

// File: rtl/vscatter_seq.sv
module vscatter_seq
   import vscat_pkg::*;
#(
   parameter int unsigned VLEN = 256
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                wide_i,
   input  logic [IMM_W-1:0]    imm_i,
   input  logic [VLEN-1:0]     base_i,
   input  logic [VLEN-1:0]     data_i,
   input  logic [VLEN/8-1:0]   pred_i,
   output logic                wr_valid_o,
   input  logic                wr_ready_i,
   output logic [ADDR_W-1:0]   wr_addr_o,
   output logic [HALF_W-1:0]   wr_data_o,
   output logic                busy_o,
   output logic                done_o
);
   localparam int unsigned N32   = VLEN / 32;
   localparam int unsigned IDX_W = $clog2(N32);

   if (VLEN % 128 != 0 || VLEN < 128) begin : g_bad_vlen
      $error("vscatter_seq: VLEN must be a nonzero multiple of 128");
   end

   seq_state_e       state_q;
   logic [N32-1:0]   act_mask, pend_q, pick_oh;
   logic [IDX_W-1:0] pick_idx;
   logic             pick_any, any_act, launch, accept, last;
   logic             wide_q;
   logic [IMM_W-1:0] imm_q;
   logic [VLEN-1:0]  base_q, data_q;

   vscat_pred_decode #(.VLEN(VLEN)) u_dec (
      .pred_i (pred_i),
      .wide_i (wide_i),
      .act_o  (act_mask)
   );

   vscat_pick #(.N(N32)) u_pick (
      .pend_i (pend_q),
      .any_o  (pick_any),
      .oh_o   (pick_oh),
      .idx_o  (pick_idx)
   );

   vscat_lane_sel #(.VLEN(VLEN)) u_lane (
      .base_i (base_q),
      .data_i (data_q),
      .wide_i (wide_q),
      .idx_i  (pick_idx),
      .imm_i  (imm_q),
      .addr_o (wr_addr_o),
      .half_o (wr_data_o)
   );

   assign any_act    = |act_mask;
   assign launch     = start_i && (state_q != ST_RUN);
   assign wr_valid_o = (state_q == ST_RUN) && pick_any;
   assign accept     = wr_valid_o && wr_ready_i;
   assign last       = accept && ((pend_q & ~pick_oh) == '0);
   assign busy_o     = (state_q == ST_RUN);
   assign done_o     = (state_q == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= '0;
         wide_q  <= 1'b0;
         imm_q   <= '0;
      end else begin
         case (state_q)
            ST_RUN: begin
               if (accept) pend_q <= pend_q & ~pick_oh;
               if (last)   state_q <= ST_DONE;
            end
            default: begin
               if (launch) begin
                  pend_q  <= act_mask;
                  wide_q  <= wide_i;
                  imm_q   <= imm_i;
                  state_q <= any_act ? ST_RUN : ST_DONE;
               end else begin
                  state_q <= ST_IDLE;
               end
            end
         endcase
      end
   end

   // Operand vectors are captured only when some lane will use them.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         data_q <= '0;
      end else if (launch && any_act) begin
         base_q <= base_i;
         data_q <= data_i;
      end
   end

endmodule

// File: rtl/vscat_seq_chk.sv
module vscat_seq_chk #(
   parameter int unsigned VLEN = 256
)(
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              wide_i,
   input logic [VLEN/8-1:0] pred_i,
   input logic              wr_valid_o,
   input logic              wr_ready_i,
   input logic [63:0]       wr_addr_o,
   input logic [15:0]       wr_data_o,
   input logic              busy_o,
   input logic              done_o
);
   localparam int unsigned N32 = VLEN / 32;
   localparam int unsigned N64 = VLEN / 64;

   logic gov_narrow, gov_wide, gov_any;

   always_comb begin
      gov_narrow = 1'b0;
      for (int e = 0; e < N32; e++) gov_narrow = gov_narrow | pred_i[e*4];
   end
   always_comb begin
      gov_wide = 1'b0;
      for (int e = 0; e < N64; e++) gov_wide = gov_wide | pred_i[e*8];
   end
   assign gov_any = wide_i ? gov_wide : gov_narrow;

   AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)); // R8

   AST_RUN_EXIT_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !(wr_valid_o && wr_ready_i) |=> busy_o); // R8

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9

   AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o); // R9

   AST_EMPTY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && !gov_any |=> done_o && !wr_valid_o); // R10

   AST_START_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i && !wr_ready_i |=> busy_o); // R11

endmodule

bind vscatter_seq vscat_seq_chk #(.VLEN(VLEN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .wide_i     (wide_i),
   .pred_i     (pred_i),
   .wr_valid_o (wr_valid_o),
   .wr_ready_i (wr_ready_i),
   .wr_addr_o  (wr_addr_o),
   .wr_data_o  (wr_data_o),
   .busy_o     (busy_o),
   .done_o     (done_o)
);

// File: tb/tb_vscatter_seq.sv
module tb_vscatter_seq;
   localparam int VLEN = 256;
   localparam int N32  = VLEN / 32;
   localparam int N64  = VLEN / 64;
   localparam int PW   = VLEN / 8;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            start_i, wide_i, wr_ready_i;
   logic [4:0]      imm_i;
   logic [VLEN-1:0] base_i, data_i;
   logic [PW-1:0]   pred_i;
   logic            wr_valid_o, busy_o, done_o;
   logic [63:0]     wr_addr_o;
   logic [15:0]     wr_data_o;

   int     n_vec = 0;
   int     n_bad = 0;
   longint cyc   = 0;
   longint unsigned rng = 64'h1234_5678_9abc_def1;

   always #2 clk = ~clk;

   vscatter_seq #(.VLEN(VLEN)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
      .imm_i(imm_i), .base_i(base_i), .data_i(data_i), .pred_i(pred_i),
      .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
      .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .busy_o(busy_o), .done_o(done_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] nxt();
      rng = rng * 64'd6364136223846793005 + 64'd1442695040888963407;
      return rng;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic run_op(input bit wide, input logic [4:0] imm, input logic [7:0] emask,
                         input int stall, input bit poke, input bit near_top);
      logic [63:0] exp_a [N32];
      logic [15:0] exp_d [N32];
      logic [63:0] ba, h_addr;
      logic [15:0] h_data;
      logic [PW-1:0] p;
      logic [VLEN-1:0] bv, dv;
      int  step, nel, cnt, got;
      bit  held, first, prev_acc, fin, rdy, exp_done;
      step = wide ? 8 : 4;
      nel  = wide ? N64 : N32;
      for (int w = 0; w < VLEN/64; w++) begin
         bv[w*64 +: 64] = nxt();
         dv[w*64 +: 64] = nxt();
      end
      if (near_top) begin
         for (int e = 0; e < N64; e++) bv[e*64 +: 64] = 64'hFFFF_FFFF_FFFF_FFC0 + 64'(e*8);
      end
      // governing bits from emask, all others random (R3)
      p = nxt()[PW-1:0];
      for (int i = 0; i < PW; i++) begin
         if (i % step == 0) p[i] = (i/step < nel) ? emask[i/step] : 1'b0;
      end
      cnt = 0;
      for (int e = 0; e < nel; e++) begin
         if (emask[e]) begin
            ba = wide ? bv[e*64 +: 64] : {32'b0, bv[e*32 +: 32]};
            exp_a[cnt] = ba + 64'(imm) * 64'd2;
            exp_d[cnt] = wide ? dv[e*64 +: 16] : dv[e*32 +: 16];
            cnt++;
         end
      end
      @(negedge clk);
      start_i = 1'b1; wide_i = wide; imm_i = imm;
      base_i = bv; data_i = dv; pred_i = p;
      @(negedge clk);
      start_i = 1'b0;
      got = 0; held = 0; first = 1; prev_acc = 0; fin = 0;
      h_addr = '0; h_data = '0;
      for (int c = 0; c < 400 && !fin; c++) begin
         rdy = (stall == 0) ? 1'b1 : (((c*5 + stall) % 3) != 0);
         wr_ready_i = rdy;
         if (poke && c == 2) begin
            start_i = 1'b1; imm_i = ~imm; base_i = ~bv; data_i = ~dv; pred_i = '1;
         end
         if (poke && c == 3) start_i = 1'b0;
         #1;
         if (held) begin
            chk("R8", "valid held", 64'(wr_valid_o), 64'd1);
            chk("R8", "addr held", wr_addr_o, h_addr);
            chk("R8", "data held", 64'(wr_data_o), 64'(h_data));
         end
         exp_done = (cnt == 0 && first) || (prev_acc && got == cnt);
         chk(cnt == 0 ? "R10" : "R9", "done", 64'(done_o), 64'(exp_done));
         if (got == cnt) chk("R6", "no extra write", 64'(wr_valid_o), 64'd0);
         if (done_o) begin
            fin = 1;
            chk("R9", "busy at done", 64'(busy_o), 64'd0);
         end else if (wr_valid_o && got < cnt) begin
            if (rdy) begin
               chk(poke ? "R11" : "R4", "addr (R7 order)", wr_addr_o, exp_a[got]);
               chk(poke ? "R11" : "R5", "data (R2 lane)", 64'(wr_data_o), 64'(exp_d[got]));
               got++; prev_acc = 1; held = 0;
            end else begin
               held = 1; h_addr = wr_addr_o; h_data = wr_data_o; prev_acc = 0;
            end
         end else begin
            prev_acc = 0;
         end
         first = 0;
         @(negedge clk);
      end
      start_i = 1'b0;
      chk("R9", "op completed", 64'(fin), 64'd1);
      chk("R6", "write count", 64'(got), 64'(cnt));
   endtask

   initial begin
      rst_n = 1'b0; start_i = 1'b0; wide_i = 1'b0; imm_i = '0;
      base_i = '0; data_i = '0; pred_i = '0; wr_ready_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "valid in reset", 64'(wr_valid_o), 64'd0);
      chk("R1", "busy in reset", 64'(busy_o), 64'd0);
      chk("R1", "done in reset", 64'(done_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "valid after reset", 64'(wr_valid_o), 64'd0);
      chk("R1", "done after reset", 64'(done_o), 64'd0);

      // every 32-bit lane mask (R2, R3, R6, R7, R10)
      for (int m = 0; m < 256; m++)
         run_op(1'b0, 5'(m ^ (m >> 5)), 8'(m), m % 4, 1'b0, 1'b0);
      // every 64-bit lane mask under each ready pattern
      for (int m = 0; m < 16; m++)
         for (int s = 0; s < 4; s++)
            run_op(1'b1, 5'(m*2 + s), 8'(m), s, 1'b0, 1'b0);
      // every immediate with bases near the top of the address space (R4 wrap)
      for (int i = 0; i < 32; i++)
         run_op(1'b1, 5'(i), 8'h0F, i % 3, 1'b0, 1'b1);
      // start pulse during a running operation (R11)
      run_op(1'b0, 5'd5, 8'hFF, 1, 1'b1, 1'b0);
      run_op(1'b1, 5'd9, 8'h0F, 2, 1'b1, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule